// File: doc/BRIEF.md
# Two-Phase Sample Capture Buffer Controller

This block sequences a single-port sample memory through two phases. In the capture phase, each converter sample strobe writes one sample into the next memory location, so the memory fills at the converter rate. When the last location has been written, the block reports that the buffer is full. It then releases the converter's data bus and switches the memory to read-out.

In the read-out phase, a slower consumer pulls the samples back with read strobes. It gets them in the same order in which they were captured. After the last location has been read, the block reports that the buffer is empty. A single counter drives the memory address from its low bits, and its extra top bit is the full flag. An arm input restarts a capture at any time.

The address width is a parameter. The intended deployment uses `ADDR_W = 16` (65536 eight-bit samples). The default is kept small so that elaboration stays light.

Top module: `capture_buffer_ctrl`

## Requirements
- R1: After reset the block is in the capture phase with the counter at zero: `conv_oe`=1, `full`=0, `full_irq`=0, `empty`=0, `rd_valid`=0.
- R2: In the capture phase, each cycle with `smp_stb`=1 stores `smp_data` at the counter's current location and advances the counter. Cycles with `smp_stb`=0 store nothing.
- R3: The strobe that writes location 2**ADDR_W-1 ends the capture phase. From the next cycle, `full`=1 and `conv_oe`=0, and `full_irq` is high for exactly that one cycle.
- R4: `conv_oe` is 1 exactly while the block is in the capture phase, and it is never high together with `full` or `empty`.
- R5: In the read-out phase, a cycle with `rd_stb`=1 produces `rd_valid`=1 in the following cycle, with `rd_data` holding the next stored sample. Samples come out in capture order, starting from location 0.
- R6: The read strobe that reads location 2**ADDR_W-1 ends the read-out phase. From the next cycle, `empty`=1 and `full`=0.
- R7: `smp_stb` outside the capture phase has no effect: it writes no location and moves no flag.
- R8: `rd_stb` outside the read-out phase has no effect: it produces no `rd_valid` pulse and does not advance the counter.
- R9: `arm`=1 in any phase clears the counter and returns the block to the capture phase in the next cycle. Any strobe in that same cycle is ignored.
- R10: `full` stays high for the whole read-out phase. It falls only when the block becomes empty or is re-armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arm | input | 1 | Restart a capture, clearing the counter |
| smp_stb | input | 1 | Converter sample strobe |
| smp_data | input | DATA_W | Converter sample |
| rd_stb | input | 1 | Consumer read strobe |
| conv_oe | output | 1 | Converter bus output enable (0 = bus released) |
| full | output | 1 | Counter top bit: buffer holds a complete capture |
| full_irq | output | 1 | One-cycle pulse when capture completes |
| empty | output | 1 | All samples have been read out |
| rd_valid | output | 1 | Read data valid, one cycle after a read strobe |
| rd_data | output | DATA_W | Read-out sample |

## Verification
Every output of this block comes from a register. A strobe, an arm or the final write or read is sampled on one rising edge, and its effect appears on the ports right after that edge: the phase flags, the `full_irq` pulse, and `rd_valid` with its sample are all due one cycle after the strobe. The bench drives inputs on the falling edge. A behavioural model updates on the same rising edge as the design, and the bench compares the design's outputs with it on the next falling edge, so every comparison lands exactly one cycle after its cause. The stimulus mixes idle gaps, strobes in the wrong phase, and re-arms in the middle of a capture and in the middle of a read-out.

// File: rtl/cap_pkg.sv
package cap_pkg;

   typedef enum logic [1:0] {
      PH_CAPTURE = 2'd0,
      PH_READOUT = 2'd1,
      PH_EMPTY   = 2'd2
   } cap_phase_e;

endpackage

// File: rtl/cap_seq.sv
module cap_seq #(
   parameter int ADDR_W = 10
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  arm,
   input  logic                  smp_stb,
   input  logic                  rd_stb,
   output cap_pkg::cap_phase_e   phase,
   output logic [ADDR_W-1:0]     addr,
   output logic                  top_bit,
   output logic                  wr_en,
   output logic                  rd_en,
   output logic                  full_irq
);
   import cap_pkg::*;

   localparam int CNT_W = ADDR_W + 1;

   logic [CNT_W-1:0] cnt_q;
   logic             last_loc;

   assign addr     = cnt_q[ADDR_W-1:0];
   assign top_bit  = cnt_q[ADDR_W];
   assign last_loc = (cnt_q[ADDR_W-1:0] == {ADDR_W{1'b1}});

   // arm has priority over both strobes
   assign wr_en = (phase == PH_CAPTURE) && smp_stb && !arm;
   assign rd_en = (phase == PH_READOUT) && rd_stb && !arm;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q    <= '0;
         phase    <= PH_CAPTURE;
         full_irq <= 1'b0;
      end else begin
         full_irq <= 1'b0;
         if (arm) begin
            cnt_q <= '0;
            phase <= PH_CAPTURE;
         end else if (wr_en) begin
            // carry into the top bit marks the buffer full; low bits restart at 0
            cnt_q <= cnt_q + 1'b1;
            if (last_loc) begin
               phase    <= PH_READOUT;
               full_irq <= 1'b1;
            end
         end else if (rd_en) begin
            // wrap past the top bit clears the full flag
            cnt_q <= cnt_q + 1'b1;
            if (last_loc) begin
               phase <= PH_EMPTY;
            end
         end
      end
   end

endmodule

// File: rtl/cap_mem.sv
module cap_mem #(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 10
) (
   input  logic              clk,
   input  logic              we,
   input  logic              re,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] store [DEPTH];

   // single port: one access per cycle, write or registered read
   always_ff @(posedge clk) begin
      if (we) begin
         store[addr] <= wdata;
      end else if (re) begin
         rdata <= store[addr];
      end
   end

endmodule

// File: rtl/cap_rdport.sv
module cap_rdport #(
   parameter int DATA_W     = 8,
   parameter bit ZERO_IDLE  = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_en,
   input  logic [DATA_W-1:0] mem_q,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_valid <= 1'b0;
      end else begin
         rd_valid <= rd_en;
      end
   end

   generate
      if (ZERO_IDLE) begin : g_zero
         assign rd_data = rd_valid ? mem_q : '0;
      end else begin : g_hold
         assign rd_data = mem_q;
      end
   endgenerate

endmodule

// File: rtl/capture_buffer_ctrl.sv
module capture_buffer_ctrl #(
   parameter int DATA_W    = 8,
   parameter int ADDR_W    = 10,
   parameter bit ZERO_IDLE = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              arm,
   input  logic              smp_stb,
   input  logic [DATA_W-1:0] smp_data,
   input  logic              rd_stb,
   output logic              conv_oe,
   output logic              full,
   output logic              full_irq,
   output logic              empty,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data
);
   import cap_pkg::*;

   generate
      if (DATA_W < 1 || DATA_W > 64) begin : g_bad_data
         $error("capture_buffer_ctrl: DATA_W out of range");
      end
      if (ADDR_W < 2 || ADDR_W > 20) begin : g_bad_addr
         $error("capture_buffer_ctrl: ADDR_W out of range");
      end
   endgenerate

   cap_phase_e        phase;
   logic [ADDR_W-1:0] mem_addr;
   logic              mem_we;
   logic              mem_re;
   logic [DATA_W-1:0] mem_q;

   cap_seq #(.ADDR_W(ADDR_W)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .arm      (arm),
      .smp_stb  (smp_stb),
      .rd_stb   (rd_stb),
      .phase    (phase),
      .addr     (mem_addr),
      .top_bit  (full),
      .wr_en    (mem_we),
      .rd_en    (mem_re),
      .full_irq (full_irq)
   );

   cap_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
      .clk   (clk),
      .we    (mem_we),
      .re    (mem_re),
      .addr  (mem_addr),
      .wdata (smp_data),
      .rdata (mem_q)
   );

   cap_rdport #(.DATA_W(DATA_W), .ZERO_IDLE(ZERO_IDLE)) u_rd (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_en    (mem_re),
      .mem_q    (mem_q),
      .rd_valid (rd_valid),
      .rd_data  (rd_data)
   );

   assign conv_oe = (phase == PH_CAPTURE);
   assign empty   = (phase == PH_EMPTY);

endmodule

// File: rtl/cap_chk.sv
module cap_chk (
   input logic clk,
   input logic rst_n,
   input logic arm,
   input logic rd_stb,
   input logic conv_oe,
   input logic full,
   input logic full_irq,
   input logic empty,
   input logic rd_valid,
   input logic wr_en
);
   // R3
   irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      full_irq |=> !full_irq);

   // R3
   irq_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      full_irq |-> (full && !conv_oe && $past(conv_oe)));

   // R4
   oe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      conv_oe |-> (!full && !empty));

   // R5
   rd_valid_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> ($past(rd_stb) && !$past(arm) && $past(full)));

   // R6
   empty_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(empty) |-> ($past(full) && !full && $past(rd_stb)));

   // R7
   no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> conv_oe);

   // R9
   arm_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      arm |=> (conv_oe && !full && !empty));

   // R10
   full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(full) |-> (empty || $past(arm)));

endmodule

bind capture_buffer_ctrl cap_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .arm      (arm),
   .rd_stb   (rd_stb),
   .conv_oe  (conv_oe),
   .full     (full),
   .full_irq (full_irq),
   .empty    (empty),
   .rd_valid (rd_valid),
   .wr_en    (mem_we)
);

// File: tb/capture_buffer_ctrl_test.sv
module capture_buffer_ctrl_test;
   localparam int DATA_W = 8;
   localparam int ADDR_W = 10;
   localparam int DEPTH  = 1 << ADDR_W;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              arm = 1'b0;
   logic              smp_stb = 1'b0;
   logic [DATA_W-1:0] smp_data = '0;
   logic              rd_stb = 1'b0;
   logic              conv_oe, full, full_irq, empty, rd_valid;
   logic [DATA_W-1:0] rd_data;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   capture_buffer_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) uut (
      .clk(clk), .rst_n(rst_n), .arm(arm), .smp_stb(smp_stb),
      .smp_data(smp_data), .rd_stb(rd_stb), .conv_oe(conv_oe),
      .full(full), .full_irq(full_irq), .empty(empty),
      .rd_valid(rd_valid), .rd_data(rd_data)
   );

   // behavioural reference: 0 capture, 1 read-out, 2 empty
   int          m_ph = 0;
   int          m_cnt = 0;
   logic [7:0]  m_q[$];
   bit          e_irq = 1'b0;
   bit          e_valid = 1'b0;
   logic [7:0]  e_data = '0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_ph = 0; m_cnt = 0; m_q.delete(); e_irq = 0; e_valid = 0;
      end else begin
         e_irq = 0; e_valid = 0;
         if (arm) begin
            m_ph = 0; m_cnt = 0; m_q.delete();
         end else if (m_ph == 0 && smp_stb) begin
            m_q.push_back(smp_data);
            m_cnt++;
            if (m_cnt == DEPTH) begin m_ph = 1; m_cnt = 0; e_irq = 1; end
         end else if (m_ph == 1 && rd_stb) begin
            e_valid = 1;
            e_data  = m_q.pop_front();
            m_cnt++;
            if (m_cnt == DEPTH) m_ph = 2;
         end
      end
   end

   task automatic chk(input bit ok, input string tag, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
      end
   endtask

   // per-clock comparison against the model, one cycle after each cause
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk(conv_oe == (m_ph == 0), "R4", "conv_oe", conv_oe, m_ph == 0);
         chk(full == (m_ph == 1), "R3/R10", "full", full, m_ph == 1);
         chk(full_irq == e_irq, "R3", "full_irq", full_irq, e_irq);
         chk(empty == (m_ph == 2), "R6", "empty", empty, m_ph == 2);
         chk(rd_valid == e_valid, "R5/R8", "rd_valid", rd_valid, e_valid);
         if (e_valid)
            chk(rd_data == e_data, "R2/R5/R7", "rd_data", rd_data, e_data);
      end
   end

   task automatic cyc(input bit s, input bit r, input bit a, input logic [7:0] d);
      @(negedge clk);
      smp_stb = s; rd_stb = r; arm = a; smp_data = d;
   endtask

   task automatic fill(input int n, input int seed);
      for (int i = 0; i < n; i++) begin
         cyc(1'b1, (i % 5) == 0, 1'b0, 8'((i * 7 + seed) & 8'hff));
         if ((i % 3) == 0) cyc(1'b0, 1'b0, 1'b0, 8'h00);
      end
   endtask

   task automatic drain(input int n);
      for (int i = 0; i < n; i++) begin
         cyc((i % 4) == 0, 1'b1, 1'b0, 8'hA5);
         if ((i % 7) == 0) cyc(1'b0, 1'b0, 1'b0, 8'h00);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         fails++;
         $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(conv_oe == 1 && full == 0 && full_irq == 0 && empty == 0 && rd_valid == 0,
          "R1", "reset flags", {conv_oe, full, full_irq, empty, rd_valid}, 5'b10000);

      // first capture with gaps and stray read strobes (R2, R8), then read-out
      fill(DEPTH, 3);
      cyc(1'b0, 1'b0, 1'b0, 8'h00);
      @(negedge clk);
      chk(full == 1 && conv_oe == 0, "R3", "full after last write", {full, conv_oe}, 2'b10);
      drain(DEPTH);
      cyc(1'b0, 1'b0, 1'b0, 8'h00);
      @(negedge clk);
      chk(empty == 1 && full == 0, "R6", "empty after last read", {empty, full}, 2'b10);

      // stray strobes while empty (R7, R8)
      for (int i = 0; i < 6; i++) cyc(1'b1, 1'b1, 1'b0, 8'h5A);
      cyc(1'b0, 1'b0, 1'b0, 8'h00);
      @(negedge clk);
      chk(rd_valid == 0 && empty == 1, "R8", "no read when empty", {rd_valid, empty}, 2'b01);

      // re-arm with a simultaneous sample strobe (R9), partial capture, re-arm
      cyc(1'b1, 1'b0, 1'b1, 8'hEE);
      cyc(1'b0, 1'b0, 1'b0, 8'h00);
      chk(conv_oe == 1 && empty == 0 && full == 0, "R9", "arm from empty",
          {conv_oe, empty, full}, 3'b100);
      fill(50, 11);
      cyc(1'b1, 1'b0, 1'b1, 8'h77);
      cyc(1'b0, 1'b0, 1'b0, 8'h00);
      chk(conv_oe == 1 && full == 0, "R9", "arm mid capture", {conv_oe, full}, 2'b10);

      // full capture, half read-out, re-arm mid read-out
      fill(DEPTH, 29);
      drain(DEPTH / 2);
      cyc(1'b0, 1'b1, 1'b1, 8'h00);
      cyc(1'b0, 1'b0, 1'b0, 8'h00);
      chk(conv_oe == 1 && full == 0 && rd_valid == 0, "R9", "arm mid read-out",
          {conv_oe, full, rd_valid}, 3'b100);

      // final complete cycle, samples written out of capture are dropped (R7)
      fill(DEPTH, 101);
      drain(DEPTH);
      cyc(1'b0, 1'b0, 1'b0, 8'h00);
      @(negedge clk);
      chk(empty == 1, "R6", "empty at end", empty, 1);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule